// File: doc/BRIEF.md
# PCI Configuration Cycle Generator

This block sits on the host's I/O port path and turns the classic address-port/data-port pair (0CF8h and 0CFCh) into PCI configuration requests. A full 32-bit write to the address port loads an internal configuration address word. Any narrower access to that port is not treated as a register access. It is passed on to the bus as an ordinary I/O cycle.

Once the enable bit of that word is set, an access to the data port becomes a configuration read or write. The block builds the issued address from a one-hot device-select bit in the upper address bits, plus the function and register fields. It hands the request to a downstream request/acknowledge interface that stands in for the real bus master.

Accesses can be trapped instead of issued. The trap is selected per device number, or for one chosen bus number. A trapped access raises a one-cycle system-management interrupt pulse in place of the bus cycle. Every other port access is forwarded unchanged as plain I/O. The host side holds its request until the block answers with a one-cycle ready.

Top module: `pci_cfg_gen`

## Requirements
- R1: After reset, dn_req, smi_pulse and host_ready are low, and a dword read of port 0CF8h returns 0.
- R2: A dword write (host_size 2) to 0CF8h loads the configuration address word and issues no downstream request. A later dword read of 0CF8h returns the stored word, also with no downstream request.
- R3: A byte (host_size 0) or word (host_size 1) access to 0CF8h is forwarded as an I/O cycle and leaves the stored word unchanged. The forwarded cycle has dn_kind 0 for a read or 1 for a write, dn_addr equal to the port, and the same size and write data.
- R4: While bit 31 of the stored word is clear, an access to 0CFCh is forwarded as a plain I/O cycle (dn_kind 0 or 1, dn_addr 0CFCh).
- R5: While bit 31 is set, a data-port write issues dn_kind 3 with the host write data, and a data-port read issues dn_kind 2. For a read, host_ready is withheld until after dn_ack, and host_rdata then carries dn_rdata.
- R6: In an issued configuration address, bits [10:8] carry the function field (stored bits [10:8]) and bits [7:2] carry the register field (stored bits [7:2]). Bits [1:0] are always 00.
- R7: The device field (stored bits [15:11]) with value d from 1 to 21 sets exactly one bit of dn_addr[31:11], namely bit 10+d.
- R8: A configuration access to device 0 or 22–31 issues no downstream request. A read completes with all ones, and a write is discarded.
- R9: If virt_dev_mask bit d is set for the addressed device d, a data-port access completes without a downstream request, pulses smi_pulse for exactly one cycle, and a read returns all ones.
- R10: If virt_bus_en is high and the bus field (stored bits [23:16]) equals virt_bus_num, the access traps as in R9. If the bus field differs, or virt_bus_en is low, the access is issued normally.
- R11: Once raised, dn_req stays high, with dn_addr, dn_kind and dn_wdata unchanged, until the cycle in which dn_ack is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host port access pending; held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | I/O port address |
| host_size | input | 2 | 0 byte, 1 word, 2 dword |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | One-cycle completion of the host access |
| virt_dev_mask | input | 32 | Per-device-number trap enables |
| virt_bus_en | input | 1 | Enables trapping of a whole bus |
| virt_bus_num | input | 8 | Bus number trapped when virt_bus_en is set |
| smi_pulse | output | 1 | One-cycle system-management interrupt |
| dn_req | output | 1 | Downstream request |
| dn_kind | output | 2 | 0 I/O read, 1 I/O write, 2 config read, 3 config write |
| dn_addr | output | 32 | Downstream address / AD image |
| dn_size | output | 2 | Transfer size, same code as host_size |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
The bench applies byte and word accesses to the address port. A design that decoded only the port number would load the register from them, and the readback would then differ. It sweeps all 32 device numbers: an off-by-one select decode shows up as a shifted AD bit, or as a request where none may exist. It writes register offsets with the two low bits set, which catches a design that passes them through into the issued address. Trap tests pair a virtualized device or bus with a neighbour that is not virtualized, exposing an inverted or over-wide match as a missing or spurious interrupt, or as a bus cycle where a trap was due.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
   typedef enum logic [1:0] {
      DN_IO_RD  = 2'd0,
      DN_IO_WR  = 2'd1,
      DN_CFG_RD = 2'd2,
      DN_CFG_WR = 2'd3
   } dn_kind_e;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2
   } xfer_size_e;

   typedef enum logic [2:0] {
      ACT_AREG_WR,
      ACT_AREG_RD,
      ACT_BUS,
      ACT_TRAP,
      ACT_ABORT
   } act_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BUSY,
      ST_DONE
   } st_e;
endpackage

// File: rtl/pci_cfg_idsel.sv
module pci_cfg_idsel #(
   parameter int AD_W      = 32,
   parameter int DEV_W     = 5,
   parameter int IDSEL_LSB = 11,
   parameter int NUM_DEV   = 21
) (
   input  logic [DEV_W-1:0] dev,
   output logic [AD_W-1:0]  idsel_vec,
   output logic             hit
);
   for (genvar b = 0; b < AD_W; b++) begin : g_bit
      if (b >= IDSEL_LSB && b < IDSEL_LSB + NUM_DEV) begin : g_sel
         assign idsel_vec[b] = (dev == DEV_W'(b - IDSEL_LSB + 1));
      end else begin : g_zero
         assign idsel_vec[b] = 1'b0;
      end
   end

   assign hit = |idsel_vec;
endmodule

// File: rtl/pci_cfg_classify.sv
module pci_cfg_classify
   import pci_cfg_pkg::*;
#(
   parameter int          PORT_W    = 16,
   parameter int          DEV_W     = 5,
   parameter int          BUS_W     = 8,
   parameter logic [15:0] ADDR_PORT = 16'h0CF8,
   parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
   input  logic [PORT_W-1:0]     host_addr,
   input  logic [1:0]            host_size,
   input  logic                  host_we,
   input  logic                  cfg_en,
   input  logic [DEV_W-1:0]      cfg_dev,
   input  logic [BUS_W-1:0]      cfg_bus,
   input  logic [2**DEV_W-1:0]   virt_dev_mask,
   input  logic                  virt_bus_en,
   input  logic [BUS_W-1:0]      virt_bus_num,
   input  logic                  idsel_hit,
   output act_e                  act,
   output dn_kind_e              kind
);
   logic is_aport, is_dport, trap;

   assign is_aport = (host_addr == PORT_W'(ADDR_PORT));
   assign is_dport = (host_addr == PORT_W'(DATA_PORT));
   assign trap     = virt_dev_mask[cfg_dev] | (virt_bus_en && (cfg_bus == virt_bus_num));

   always_comb begin
      kind = host_we ? DN_IO_WR : DN_IO_RD;
      act  = ACT_BUS;
      if (is_aport && (xfer_size_e'(host_size) == SZ_DWORD)) begin
         act = host_we ? ACT_AREG_WR : ACT_AREG_RD;
      end else if (is_dport && cfg_en) begin
         kind = host_we ? DN_CFG_WR : DN_CFG_RD;
         if (trap)           act = ACT_TRAP;
         else if (idsel_hit) act = ACT_BUS;
         else                act = ACT_ABORT;
      end
   end
endmodule

// File: rtl/pci_cfg_gen.sv
module pci_cfg_gen
   import pci_cfg_pkg::*;
#(
   parameter int          AD_W      = 32,
   parameter int          PORT_W    = 16,
   parameter int          DEV_W     = 5,
   parameter int          BUS_W     = 8,
   parameter int          IDSEL_LSB = 11,
   parameter int          NUM_DEV   = 21,
   parameter logic [15:0] ADDR_PORT = 16'h0CF8,
   parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_valid,
   input  logic                host_we,
   input  logic [PORT_W-1:0]   host_addr,
   input  logic [1:0]          host_size,
   input  logic [AD_W-1:0]     host_wdata,
   output logic [AD_W-1:0]     host_rdata,
   output logic                host_ready,
   input  logic [2**DEV_W-1:0] virt_dev_mask,
   input  logic                virt_bus_en,
   input  logic [BUS_W-1:0]    virt_bus_num,
   output logic                smi_pulse,
   output logic                dn_req,
   output logic [1:0]          dn_kind,
   output logic [AD_W-1:0]     dn_addr,
   output logic [1:0]          dn_size,
   output logic [AD_W-1:0]     dn_wdata,
   input  logic                dn_ack,
   input  logic [AD_W-1:0]     dn_rdata
);
   localparam int FN_LSB  = 8;
   localparam int DEV_LSB = FN_LSB + 3;
   localparam int BUS_LSB = DEV_LSB + DEV_W;
   localparam int EN_BIT  = AD_W - 1;

   if (AD_W < 32) begin : g_bad_ad_w
      $error("pci_cfg_gen: AD_W must be at least 32");
   end
   if (IDSEL_LSB < DEV_LSB) begin : g_bad_lsb
      $error("pci_cfg_gen: IDSEL_LSB overlaps function/register bits");
   end
   if (IDSEL_LSB + NUM_DEV > AD_W) begin : g_bad_ndev
      $error("pci_cfg_gen: device-select bits exceed AD width");
   end
   if (NUM_DEV >= 2**DEV_W) begin : g_bad_dev_w
      $error("pci_cfg_gen: DEV_W too narrow for NUM_DEV");
   end
   if (BUS_LSB + BUS_W > EN_BIT) begin : g_bad_bus
      $error("pci_cfg_gen: bus field collides with enable bit");
   end

   st_e             state_q;
   logic [AD_W-1:0] cfg_addr_q;
   logic            dn_req_q, smi_q;
   dn_kind_e        dn_kind_q;
   logic [AD_W-1:0] dn_addr_q, dn_wdata_q, rdata_q;
   logic [1:0]      dn_size_q;

   logic [AD_W-1:0] idsel_vec;
   logic            idsel_hit;
   act_e            act;
   dn_kind_e        kind;

   pci_cfg_idsel #(
      .AD_W(AD_W), .DEV_W(DEV_W), .IDSEL_LSB(IDSEL_LSB), .NUM_DEV(NUM_DEV)
   ) u_idsel (
      .dev       (cfg_addr_q[DEV_LSB +: DEV_W]),
      .idsel_vec (idsel_vec),
      .hit       (idsel_hit)
   );

   pci_cfg_classify #(
      .PORT_W(PORT_W), .DEV_W(DEV_W), .BUS_W(BUS_W),
      .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
   ) u_classify (
      .host_addr     (host_addr),
      .host_size     (host_size),
      .host_we       (host_we),
      .cfg_en        (cfg_addr_q[EN_BIT]),
      .cfg_dev       (cfg_addr_q[DEV_LSB +: DEV_W]),
      .cfg_bus       (cfg_addr_q[BUS_LSB +: BUS_W]),
      .virt_dev_mask (virt_dev_mask),
      .virt_bus_en   (virt_bus_en),
      .virt_bus_num  (virt_bus_num),
      .idsel_hit     (idsel_hit),
      .act           (act),
      .kind          (kind)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cfg_addr_q <= '0;
         dn_req_q   <= 1'b0;
         smi_q      <= 1'b0;
         dn_kind_q  <= DN_IO_RD;
         dn_addr_q  <= '0;
         dn_wdata_q <= '0;
         dn_size_q  <= '0;
         rdata_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (host_valid) begin
               state_q <= ST_DONE;
               rdata_q <= '1;
               case (act)
                  ACT_AREG_WR: begin
                     cfg_addr_q <= host_wdata;
                     rdata_q    <= '0;
                  end
                  ACT_AREG_RD: rdata_q <= cfg_addr_q;
                  ACT_TRAP:    smi_q   <= 1'b1;
                  ACT_BUS: begin
                     state_q    <= ST_BUSY;
                     dn_req_q   <= 1'b1;
                     dn_kind_q  <= kind;
                     dn_size_q  <= host_size;
                     dn_wdata_q <= host_wdata;
                     if (kind == DN_CFG_RD || kind == DN_CFG_WR)
                        dn_addr_q <= idsel_vec | AD_W'({cfg_addr_q[DEV_LSB-1:2], 2'b00});
                     else
                        dn_addr_q <= AD_W'(host_addr);
                  end
                  default: ;
               endcase
            end
            ST_BUSY: if (dn_ack) begin
               dn_req_q <= 1'b0;
               rdata_q  <= dn_rdata;
               state_q  <= ST_DONE;
            end
            default: begin
               smi_q   <= 1'b0;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign host_ready = (state_q == ST_DONE);
   assign host_rdata = rdata_q;
   assign smi_pulse  = smi_q;
   assign dn_req     = dn_req_q;
   assign dn_kind    = dn_kind_q;
   assign dn_addr    = dn_addr_q;
   assign dn_size    = dn_size_q;
   assign dn_wdata   = dn_wdata_q;
endmodule

// File: rtl/pci_cfg_gen_chk.sv
module pci_cfg_gen_chk #(
   parameter int AD_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            host_ready,
   input logic            smi_pulse,
   input logic            dn_req,
   input logic [1:0]      dn_kind,
   input logic [AD_W-1:0] dn_addr,
   input logic [AD_W-1:0] dn_wdata,
   input logic            dn_ack
);
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_kind) && $stable(dn_wdata));

   a_r9_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
      smi_pulse |=> !smi_pulse);

   a_r9_smi_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      smi_pulse |-> !dn_req);

   a_r7_idsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && dn_kind[1] |-> $countones(dn_addr[AD_W-1:11]) == 1);

   a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && dn_kind[1] |-> dn_addr[1:0] == 2'b00);

   a_r5_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> !dn_req);
endmodule

bind pci_cfg_gen pci_cfg_gen_chk #(.AD_W(AD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_ready (host_ready),
   .smi_pulse  (smi_pulse),
   .dn_req     (dn_req),
   .dn_kind    (dn_kind),
   .dn_addr    (dn_addr),
   .dn_wdata   (dn_wdata),
   .dn_ack     (dn_ack)
);

// File: tb/pci_cfg_gen_tb_top.sv
module pci_cfg_gen_tb_top;
   localparam int ACK_DLY = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0, host_we = 1'b0;
   logic [15:0] host_addr = '0;
   logic [1:0]  host_size = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_ready;
   logic [31:0] virt_dev_mask = '0;
   logic        virt_bus_en = 1'b0;
   logic [7:0]  virt_bus_num = '0;
   logic        smi_pulse;
   logic        dn_req;
   logic [1:0]  dn_kind;
   logic [31:0] dn_addr;
   logic [1:0]  dn_size;
   logic [31:0] dn_wdata;
   logic        dn_ack = 1'b0;
   logic [31:0] dn_rdata = '0;

   int n_chk = 0, n_bad = 0;
   int req_cnt = 0, smi_cnt = 0, wait_cnt = 0, cyc_total = 0;
   logic        seen = 1'b0;
   logic [1:0]  cap_kind, cap_size;
   logic [31:0] cap_addr, cap_wdata;
   logic [31:0] resp_data = 32'hC0DE_0001;

   always #5 clk = ~clk;

   pci_cfg_gen dut_i (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // downstream responder, sampled on the falling edge
   always @(negedge clk) begin
      cyc_total++;
      if (smi_pulse) smi_cnt++;
      if (dn_ack) begin
         dn_ack = 1'b0;
         seen = 1'b0;
      end else if (dn_req) begin
         if (!seen) begin
            seen = 1'b1;
            req_cnt++;
            wait_cnt = 0;
            cap_kind = dn_kind; cap_addr = dn_addr;
            cap_size = dn_size; cap_wdata = dn_wdata;
         end
         wait_cnt++;
         if (wait_cnt >= ACK_DLY) begin
            chk("R11 addr held", dn_addr, cap_addr);
            dn_rdata = resp_data;
            dn_ack = 1'b1;
         end
      end
   end

   initial begin
      while (cyc_total < 100000) @(negedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   task automatic xfer(input logic [15:0] a, input logic [1:0] sz, input logic we,
                       input logic [31:0] wd, output logic [31:0] rd, output int cyc);
      @(negedge clk);
      host_addr = a; host_size = sz; host_we = we; host_wdata = wd; host_valid = 1'b1;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!host_ready && cyc < 1000);
      rd = host_rdata;
      host_valid = 1'b0;
   endtask

   function automatic logic [31:0] caddr(input logic en, input int bus, input int dev,
                                         input int fn, input int off);
      return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 8'(off)};
   endfunction

   function automatic logic [31:0] exp_cfg(input int dev, input int fn, input int off);
      return (32'd1 << (10 + dev)) | (32'(fn) << 8) | (32'(off) & 32'hFC);
   endfunction

   task automatic t_reset();
      logic [31:0] rd; int c;
      chk("R1 dn_req", {31'd0, dn_req}, 0);
      chk("R1 smi", {31'd0, smi_pulse}, 0);
      chk("R1 ready", {31'd0, host_ready}, 0);
      xfer(16'h0CF8, 2, 0, 0, rd, c);
      chk("R1 addr reg reset", rd, 0);
   endtask

   task automatic t_areg();
      logic [31:0] rd; int c, r0;
      r0 = req_cnt;
      xfer(16'h0CF8, 2, 1, 32'h8012_3A5C, rd, c);
      xfer(16'h0CF8, 2, 0, 0, rd, c);
      chk("R2 readback", rd, 32'h8012_3A5C);
      chk("R2 no downstream", req_cnt - r0, 0);
   endtask

   task automatic t_partial();
      logic [31:0] rd; int c, r0;
      r0 = req_cnt;
      xfer(16'h0CF8, 0, 1, 32'h0000_0077, rd, c);
      chk("R3 byte wr forwarded", req_cnt - r0, 1);
      chk("R3 byte wr kind", {30'd0, cap_kind}, 1);
      chk("R3 byte wr addr", cap_addr, 32'h0CF8);
      chk("R3 byte wr size/data", {cap_size, cap_wdata[29:0]}, {2'd0, 30'h77});
      resp_data = 32'h0000_BEEF;
      xfer(16'h0CF8, 1, 0, 0, rd, c);
      chk("R3 word rd kind", {30'd0, cap_kind}, 0);
      chk("R3 word rd data", rd, 32'h0000_BEEF);
      xfer(16'h0CF8, 2, 0, 0, rd, c);
      chk("R3 reg unchanged", rd, 32'h8012_3A5C);
   endtask

   task automatic t_disabled();
      logic [31:0] rd; int c, r0;
      xfer(16'h0CF8, 2, 1, caddr(0, 0, 3, 0, 0), rd, c);
      r0 = req_cnt;
      xfer(16'h0CFC, 2, 1, 32'h1111_2222, rd, c);
      chk("R4 forwarded", req_cnt - r0, 1);
      chk("R4 io kind", {30'd0, cap_kind}, 1);
      chk("R4 io addr", cap_addr, 32'h0CFC);
   endtask

   task automatic t_cfg_rw();
      logic [31:0] rd; int c;
      xfer(16'h0CF8, 2, 1, caddr(1, 0, 3, 2, 8'h7F), rd, c);
      xfer(16'h0CFC, 2, 1, 32'hA5A5_0F0F, rd, c);
      chk("R5 cfg wr kind", {30'd0, cap_kind}, 3);
      chk("R5 cfg wr data", cap_wdata, 32'hA5A5_0F0F);
      chk("R6/R7 cfg addr low bits 00", cap_addr, exp_cfg(3, 2, 8'h7F));
      resp_data = 32'h1234_5678;
      xfer(16'h0CFC, 2, 0, 0, rd, c);
      chk("R5 cfg rd kind", {30'd0, cap_kind}, 2);
      chk("R5 cfg rd data", rd, 32'h1234_5678);
      chk("R5 stalled past ack", {31'd0, c > ACK_DLY}, 1);
   endtask

   task automatic t_sweep();
      logic [31:0] rd; int c, r0;
      for (int d = 0; d < 32; d++) begin
         resp_data = 32'h5000_0000 + 32'(d);
         xfer(16'h0CF8, 2, 1, caddr(1, 0, d, 1, 8'h10), rd, c);
         r0 = req_cnt;
         xfer(16'h0CFC, 2, 0, 0, rd, c);
         if (d >= 1 && d <= 21) begin
            chk("R7 idsel issued", req_cnt - r0, 1);
            chk("R7 idsel addr", cap_addr, exp_cfg(d, 1, 8'h10));
         end else begin
            chk("R8 no request", req_cnt - r0, 0);
            chk("R8 read all ones", rd, 32'hFFFF_FFFF);
         end
      end
      xfer(16'h0CF8, 2, 1, caddr(1, 0, 25, 0, 0), rd, c);
      r0 = req_cnt;
      xfer(16'h0CFC, 2, 1, 32'hDEAD_0000, rd, c);
      chk("R8 write discarded", req_cnt - r0, 0);
   endtask

   task automatic t_virt_dev();
      logic [31:0] rd; int c, r0, s0;
      virt_dev_mask = 32'h0000_0020;
      xfer(16'h0CF8, 2, 1, caddr(1, 0, 5, 0, 0), rd, c);
      r0 = req_cnt; s0 = smi_cnt;
      xfer(16'h0CFC, 2, 0, 0, rd, c);
      @(negedge clk);
      chk("R9 smi once", smi_cnt - s0, 1);
      chk("R9 no request", req_cnt - r0, 0);
      chk("R9 read ones", rd, 32'hFFFF_FFFF);
      xfer(16'h0CF8, 2, 1, caddr(1, 0, 6, 0, 0), rd, c);
      r0 = req_cnt; s0 = smi_cnt;
      xfer(16'h0CFC, 2, 0, 0, rd, c);
      chk("R9 neighbour not trapped", {req_cnt - r0, smi_cnt - s0}, {32'd1, 32'd0});
      virt_dev_mask = '0;
   endtask

   task automatic t_virt_bus();
      logic [31:0] rd; int c, r0, s0;
      virt_bus_en = 1'b1; virt_bus_num = 8'd3;
      xfer(16'h0CF8, 2, 1, caddr(1, 3, 2, 0, 0), rd, c);
      r0 = req_cnt; s0 = smi_cnt;
      xfer(16'h0CFC, 2, 1, 32'h1, rd, c);
      @(negedge clk);
      chk("R10 bus trap smi", smi_cnt - s0, 1);
      chk("R10 bus trap no request", req_cnt - r0, 0);
      xfer(16'h0CF8, 2, 1, caddr(1, 4, 2, 0, 0), rd, c);
      r0 = req_cnt; s0 = smi_cnt;
      xfer(16'h0CFC, 2, 1, 32'h2, rd, c);
      chk("R10 other bus issued", {req_cnt - r0, smi_cnt - s0}, {32'd1, 32'd0});
      virt_bus_en = 1'b0;
      xfer(16'h0CF8, 2, 1, caddr(1, 3, 2, 0, 0), rd, c);
      r0 = req_cnt;
      xfer(16'h0CFC, 2, 1, 32'h3, rd, c);
      chk("R10 bus trap disabled", req_cnt - r0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_areg();
      t_partial();
      t_disabled();
      t_cfg_rw();
      t_sweep();
      t_virt_dev();
      t_virt_bus();
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule